// File: doc/BRIEF.md
# Switch-Driven Morse Code Keyer

The keyer reads a 6-bit character number from static switches and flashes the matching Morse sequence on a single lamp output. Thirty-nine symbols are recognised: the letters, the ten digits, the period, the comma and the question mark. Every element duration is a whole number of timing units. One unit is one pulse period of an internal tick generator, which divides the system clock (100 MHz down to 10 Hz by default).

The switch value passes through a two-flop synchronizer and then through a combinational symbol table. For each symbol the table gives an element pattern, the number of elements used, and the symbol's body length in units. A sequencer steps through the pattern and turns the lamp on and off. While the code stays the same, the character repeats, with a three-unit pause between repeats. If the code changes mid-character, playback stops at once and the new character starts after the pause. Any code outside the symbol set keeps the lamp dark and raises the error output.

Top module: `morse_keyer`

## Requirements
- R1: Codes 1 to 39 are valid and hold `err` low. Code 0 and codes 40 to 63 are invalid and hold `err` high.
- R2: While the synchronized code is invalid, `lamp` stays low and `busy` stays low.
- R3: A dot lights the lamp for exactly 1 unit (TICK_DIV clock cycles). A dash lights it for exactly 3 units.
- R4: Two elements of the same character are separated by exactly 1 unit of dark lamp.
- R5: Codes 1 to 26 play A to Z, codes 27 to 36 play digits 0 to 9, and codes 37, 38 and 39 play period, comma and question mark, using standard Morse. Elements play from the first element of the symbol to the last.
- R6: The span of a character, from the first lamp-on to the last lamp-off, equals the table's 7-bit body length: the sum of the element units plus one unit per internal gap.
- R7: After the last element the lamp stays dark for exactly 3 units, and then the same character plays again. `busy` is high whenever the lamp is lit and through that pause.
- R8: A change to another valid code while an element or an internal gap is playing turns the lamp off within 3 clock cycles of the switch change. The new character's first element follows after the pause.
- R9: A switch change reaches `err` after exactly two rising clock edges, never after one.
- R10: The lamp is switched on only in the cycle after a tick pulse. It is switched off only after a tick, an abort or an invalid code.
- R11: During and right after synchronous reset, `lamp` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 6 | Character number from static switches |
| lamp | output | 1 | Lamp drive, high while an element is sounding |
| busy | output | 1 | High while a character or its trailing pause is playing |
| err | output | 1 | High while the synchronized code is outside 1 to 39 |

## Verification
The hardest case to reach from the ports is an abort that lands inside a dash. The new code must arrive after the lamp has risen but before the three-unit element ends. It must also be told apart from an ordinary element end, which lines up with a tick. The bench plays the all-dash digit zero, waits for the lamp's rising edge and switches to a one-dot letter a single cycle later. A dash would still be lit three cycles on, so a dark lamp there can only come from the abort. The bench then checks that the pause is shortened to no more than three units and that the next character is the new one.

// File: rtl/morse_pkg.sv
package morse_pkg;

  localparam int CODE_W        = 6;
  localparam int PAT_W         = 6;
  localparam int LEN_W         = 3;
  localparam int SPAN_W        = 7;
  localparam int NUM_SYMS      = 39;
  localparam int FIRST_DIGIT   = 27;
  localparam int FIRST_PUNCT   = 37;
  localparam int DOT_UNITS     = 1;
  localparam int DASH_UNITS    = 3;
  localparam int ELEM_GAP      = 1;
  localparam int CHAR_GAP      = 3;
  localparam int UCNT_W        = 2;

  typedef struct packed {
    logic              valid;
    logic [LEN_W-1:0]  len;
    logic [PAT_W-1:0]  pat;
    logic [SPAN_W-1:0] span;
  } sym_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SPACE = 2'd2,
    ST_GAP   = 2'd3
  } seq_st_t;

  // Units an element occupies: dash when the pattern bit is 1.
  function automatic logic [UCNT_W-1:0] elem_units(input logic dash);
    return dash ? UCNT_W'(DASH_UNITS) : UCNT_W'(DOT_UNITS);
  endfunction

  // Digits: leading dots then dashes for 0..5, leading dashes then dots for 6..9.
  function automatic logic [PAT_W-1:0] digit_pat(input int d);
    int v;
    if (d <= 5) v = (1 << (5 - d)) - 1;
    else        v = ((1 << (d - 5)) - 1) << (10 - d);
    return PAT_W'(v);
  endfunction

  // Body length: element units plus one gap between neighbours.
  function automatic logic [SPAN_W-1:0] body_span(input logic [LEN_W-1:0] len,
                                                  input logic [PAT_W-1:0] pat);
    int s;
    s = 0;
    for (int i = 0; i < PAT_W; i++) begin
      if (i < int'(len)) s += pat[i] ? DASH_UNITS : DOT_UNITS;
    end
    if (len != '0) s += (int'(len) - 1) * ELEM_GAP;
    return SPAN_W'(s);
  endfunction

  // Pattern is right aligned; element k of n is bit n-1-k.
  function automatic sym_t morse_lookup(input logic [CODE_W-1:0] c);
    sym_t e;
    e.valid = 1'b1;
    e.len   = '0;
    e.pat   = '0;
    if (int'(c) >= FIRST_DIGIT && int'(c) < FIRST_PUNCT) begin
      e.len = LEN_W'(5);
      e.pat = digit_pat(int'(c) - FIRST_DIGIT);
    end else begin
      case (c)
        6'd1:  begin e.len = 3'd2; e.pat = 6'b000001; end
        6'd2:  begin e.len = 3'd4; e.pat = 6'b001000; end
        6'd3:  begin e.len = 3'd4; e.pat = 6'b001010; end
        6'd4:  begin e.len = 3'd3; e.pat = 6'b000100; end
        6'd5:  begin e.len = 3'd1; e.pat = 6'b000000; end
        6'd6:  begin e.len = 3'd4; e.pat = 6'b000010; end
        6'd7:  begin e.len = 3'd3; e.pat = 6'b000110; end
        6'd8:  begin e.len = 3'd4; e.pat = 6'b000000; end
        6'd9:  begin e.len = 3'd2; e.pat = 6'b000000; end
        6'd10: begin e.len = 3'd4; e.pat = 6'b000111; end
        6'd11: begin e.len = 3'd3; e.pat = 6'b000101; end
        6'd12: begin e.len = 3'd4; e.pat = 6'b000100; end
        6'd13: begin e.len = 3'd2; e.pat = 6'b000011; end
        6'd14: begin e.len = 3'd2; e.pat = 6'b000010; end
        6'd15: begin e.len = 3'd3; e.pat = 6'b000111; end
        6'd16: begin e.len = 3'd4; e.pat = 6'b000110; end
        6'd17: begin e.len = 3'd4; e.pat = 6'b001101; end
        6'd18: begin e.len = 3'd3; e.pat = 6'b000010; end
        6'd19: begin e.len = 3'd3; e.pat = 6'b000000; end
        6'd20: begin e.len = 3'd1; e.pat = 6'b000001; end
        6'd21: begin e.len = 3'd3; e.pat = 6'b000001; end
        6'd22: begin e.len = 3'd4; e.pat = 6'b000001; end
        6'd23: begin e.len = 3'd3; e.pat = 6'b000011; end
        6'd24: begin e.len = 3'd4; e.pat = 6'b001001; end
        6'd25: begin e.len = 3'd4; e.pat = 6'b001011; end
        6'd26: begin e.len = 3'd4; e.pat = 6'b001100; end
        6'd37: begin e.len = 3'd6; e.pat = 6'b010101; end
        6'd38: begin e.len = 3'd6; e.pat = 6'b110011; end
        6'd39: begin e.len = 3'd6; e.pat = 6'b001100; end
        default: e.valid = 1'b0;
      endcase
    end
    e.span = body_span(e.len, e.pat);
    return e;
  endfunction

endpackage

// File: rtl/morse_tick_gen.sv
module morse_tick_gen #(
  parameter int DIV = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_q == LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/morse_sync.sv
module morse_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/morse_table.sv
module morse_table
  import morse_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output sym_t              sym
);
  always_comb sym = morse_lookup(code);
endmodule

// File: rtl/morse_sequencer.sv
module morse_sequencer
  import morse_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  input  sym_t              sym,
  output logic              lamp,
  output logic              busy,
  output logic              abort,
  output logic              char_start,
  output logic              char_done
);
  seq_st_t             st_q;
  logic [UCNT_W-1:0]   units_q;
  logic [LEN_W-1:0]    idx_q;
  logic [CODE_W-1:0]   cur_q;
  logic                unit_end;
  logic [LEN_W-1:0]    first_idx;

  assign first_idx  = sym.len - 1'b1;
  assign unit_end   = tick && (units_q == UCNT_W'(1));
  assign abort      = sym.valid && (code != cur_q) &&
                      (st_q == ST_MARK || st_q == ST_SPACE);
  assign char_start = sym.valid && tick &&
                      (st_q == ST_IDLE || (st_q == ST_GAP && units_q == UCNT_W'(1)));
  assign char_done  = sym.valid && !abort && st_q == ST_MARK &&
                      unit_end && idx_q == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      units_q <= '0;
      idx_q   <= '0;
      cur_q   <= '0;
    end else if (!sym.valid) begin
      st_q    <= ST_IDLE;
      units_q <= '0;
    end else if (char_start) begin
      st_q    <= ST_MARK;
      cur_q   <= code;
      idx_q   <= first_idx;
      units_q <= elem_units(sym.pat[first_idx]);
    end else if (abort) begin
      st_q    <= ST_GAP;
      units_q <= UCNT_W'(CHAR_GAP);
    end else begin
      unique case (st_q)
        ST_MARK: begin
          if (char_done) begin
            st_q    <= ST_GAP;
            units_q <= UCNT_W'(CHAR_GAP);
          end else if (unit_end) begin
            st_q    <= ST_SPACE;
            units_q <= UCNT_W'(ELEM_GAP);
            idx_q   <= idx_q - 1'b1;
          end else if (tick) begin
            units_q <= units_q - 1'b1;
          end
        end
        ST_SPACE: begin
          if (unit_end) begin
            st_q    <= ST_MARK;
            units_q <= elem_units(sym.pat[idx_q]);
          end else if (tick) begin
            units_q <= units_q - 1'b1;
          end
        end
        ST_GAP: begin
          if (tick) units_q <= units_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign lamp = (st_q == ST_MARK);
  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/morse_keyer.sv
module morse_keyer
  import morse_pkg::*;
#(
  parameter int TICK_DIV    = 10_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic              lamp,
  output logic              busy,
  output logic              err
);
  logic              tick_w;
  logic [CODE_W-1:0] code_s;
  sym_t              sym_w;
  logic              abort_w;
  logic              start_w;
  logic              done_w;
  logic [SPAN_W-1:0] span_w;

  morse_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  morse_sync #(.W(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (code_in),
    .q  (code_s)
  );

  morse_table u_table (
    .code(code_s),
    .sym (sym_w)
  );

  morse_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .code      (code_s),
    .sym       (sym_w),
    .lamp      (lamp),
    .busy      (busy),
    .abort     (abort_w),
    .char_start(start_w),
    .char_done (done_w)
  );

  assign span_w = sym_w.span;
  assign err    = !sym_w.valid;
endmodule

// File: rtl/morse_keyer_checker.sv
module morse_keyer_checker
  import morse_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              lamp,
  input logic              busy,
  input logic              err,
  input logic              abort,
  input logic              char_start,
  input logic              char_done,
  input logic [SPAN_W-1:0] span
);
  logic              in_body_q;
  logic [SPAN_W-1:0] seen_q;
  logic [SPAN_W-1:0] span_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_body_q <= 1'b0;
      seen_q    <= '0;
      span_q    <= '0;
    end else if (char_start) begin
      in_body_q <= 1'b1;
      seen_q    <= '0;
      span_q    <= span;
    end else begin
      if (char_done || abort || err) in_body_q <= 1'b0;
      if (tick && in_body_q)         seen_q    <= seen_q + 1'b1;
    end
  end

  a_r2_invalid_dark: assert property (@(posedge clk) disable iff (rst)
    (err && $past(err)) |-> (!lamp && !busy));

  a_r10_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(lamp) |-> $past(tick));

  a_r10_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(lamp) |-> ($past(tick) || $past(abort) || $past(err)));

  a_r7_lamp_busy: assert property (@(posedge clk) disable iff (rst)
    lamp |-> busy);

  a_r8_abort_dark: assert property (@(posedge clk) disable iff (rst)
    abort |=> !lamp);

  a_r6_body_span: assert property (@(posedge clk) disable iff (rst)
    (char_done && in_body_q) |-> (seen_q + 1'b1 == span_q));
endmodule

bind morse_keyer morse_keyer_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick_w),
  .lamp      (lamp),
  .busy      (busy),
  .err       (err),
  .abort     (abort_w),
  .char_start(start_w),
  .char_done (done_w),
  .span      (span_w)
);

// File: tb/test_morse_keyer.sv
module test_morse_keyer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] code_in = 6'd0;
  logic       lamp, busy, err;
  int         errors = 0;
  int         checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  morse_keyer #(.TICK_DIV(DIV)) i_morse_keyer (
    .clk    (clk),
    .rst    (rst),
    .code_in(code_in),
    .lamp   (lamp),
    .busy   (busy),
    .err    (err)
  );

  function automatic string expect_str(input int c);
    string letters [26] = '{".-", "-...", "-.-.", "-..", ".", "..-.", "--.", "....",
                            "..", ".---", "-.-", ".-..", "--", "-.", "---", ".--.",
                            "--.-", ".-.", "...", "-", "..-", "...-", ".--", "-..-",
                            "-.--", "--.."};
    string digits [10] = '{"-----", ".----", "..---", "...--", "....-",
                           ".....", "-....", "--...", "---..", "----."};
    if (c >= 1 && c <= 26)  return letters[c-1];
    if (c >= 27 && c <= 36) return digits[c-27];
    if (c == 37) return ".-.-.-";
    if (c == 38) return "--..--";
    if (c == 39) return "..--..";
    return "";
  endfunction

  function automatic int expect_span_cycles(input string s);
    int u = 0;
    for (int i = 0; i < s.len(); i++) u += (s[i] == "-") ? 3 : 1;
    u += s.len() - 1;
    return u * DIV;
  endfunction

  task automatic report_summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fresh_start();
    int low = 0;
    cyc(3);
    forever begin
      @(negedge clk);
      if (lamp) begin
        if (low >= 3*DIV) return;
        low = 0;
      end else low++;
    end
  endtask

  task automatic measure(output string s, output bit gaps_ok,
                         output int final_gap, output int body);
    int hi, lo;
    s = ""; gaps_ok = 1'b1; final_gap = 0; body = 0;
    for (int e = 0; e < 8; e++) begin
      hi = 1;
      while (1) begin @(negedge clk); if (!lamp) break; hi++; end
      body += hi;
      if (hi == DIV)        s = {s, "."};
      else if (hi == 3*DIV) s = {s, "-"};
      else                  s = {s, "?"};
      lo = 1;
      while (1) begin @(negedge clk); if (lamp) break; lo++; end
      if (lo != DIV) begin final_gap = lo; return; end
      body += lo;
    end
    gaps_ok = 1'b0;
  endtask

  task automatic play_check(input int c);
    string s, e;
    bit    gok;
    int    fg, body;
    code_in = 6'(c);
    wait_fresh_start();
    measure(s, gok, fg, body);
    e = expect_str(c);
    // R3 R5: element durations and order
    check(s == e, "R5/R3", $sformatf("code %0d pattern", c), s, e);
    // R4: internal gaps, R6: body span
    check(gok && body == expect_span_cycles(e), "R4/R6", $sformatf("code %0d span", c),
          $sformatf("%0d", body), $sformatf("%0d", expect_span_cycles(e)));
    // R7: trailing pause then repeat while busy
    check(fg == 3*DIV && busy && lamp, "R7", $sformatf("code %0d pause", c),
          $sformatf("%0d busy=%0b", fg, busy), $sformatf("%0d busy=1", 3*DIV));
    check(err == 1'b0, "R1", $sformatf("code %0d err", c), $sformatf("%0b", err), "0");
  endtask

  task automatic dark_check(input int c);
    bit bad = 1'b0;
    code_in = 6'(c);
    cyc(4);
    for (int i = 0; i < 8*DIV; i++) begin
      @(negedge clk);
      if (lamp || busy || !err) bad = 1'b1;
    end
    // R1 R2: invalid code
    check(!bad, "R2/R1", $sformatf("code %0d dark", c),
          $sformatf("lamp=%0b busy=%0b err=%0b", lamp, busy, err), "lamp=0 busy=0 err=1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report_summary();
    $finish;
  end

  initial begin
    int lo, c;
    string s;
    bit gok;
    int fg, body;
    cyc(5);
    check(!lamp && !busy, "R11", "during reset", $sformatf("%0b%0b", lamp, busy), "00");
    rst = 1'b0;
    cyc(1);
    check(!lamp && !busy && err, "R11", "after reset",
          $sformatf("lamp=%0b busy=%0b err=%0b", lamp, busy, err), "lamp=0 busy=0 err=1");

    for (int k = 1; k <= 39; k++) play_check(k);
    dark_check(0);
    dark_check(40);
    dark_check(63);

    // R9: synchronizer latency
    code_in = 6'd5;
    cyc(6);
    code_in = 6'd0;
    @(posedge clk); @(negedge clk);
    check(err == 1'b0, "R9", "err after one edge", $sformatf("%0b", err), "0");
    @(posedge clk); @(negedge clk);
    check(err == 1'b1, "R9", "err after two edges", $sformatf("%0b", err), "1");

    // R8: abort inside a dash of digit zero, switch to E
    code_in = 6'd27;
    wait_fresh_start();
    code_in = 6'd5;
    cyc(3);
    check(!lamp, "R8", "lamp after abort", $sformatf("%0b", lamp), "0");
    lo = 0;
    while (!lamp) begin @(negedge clk); lo++; end
    check(lo >= 2*DIV && lo <= 3*DIV + 1, "R8", "shortened pause",
          $sformatf("%0d", lo), $sformatf("%0d..%0d", 2*DIV, 3*DIV + 1));
    measure(s, gok, fg, body);
    check(s == "." && fg == 3*DIV, "R8", "next character",
          $sformatf("%s/%0d", s, fg), $sformatf("./%0d", 3*DIV));

    void'($urandom(32'd20251));
    for (int k = 0; k < 30; k++) begin
      c = int'($urandom % 64);
      if (c >= 1 && c <= 39) play_check(c);
      else dark_check(c);
    end

    report_summary();
    $finish;
  end
endmodule